// File: doc/BRIEF.md
# Dual Serial-Input Segmented DAC Front End

This block sits in front of a two-channel audio converter core. Each channel has its own serial data line and its own latch strobe, and one bit clock is shared by both. Bits are shifted in most significant bit first on the rising clock edge. When a channel's strobe goes from high to low, the last full sample shifted in moves into that channel's holding register. The other channel is not touched.

The held two's-complement sample is turned into offset binary by inverting its sign bit. The top bits then select how many equally weighted segment switches are on, as a thermometer code. The remaining bits drive the binary ladder switches unchanged. The outputs are switch-control words only. Strobe edges are detected in the bit-clock domain. The data and strobe lines of the two channels may be wired together, and the two channels then produce identical codes.

Top module: `dual_dac_fe`

## Requirements
- R1: Serial data is shifted in MSB first on each rising clock edge. A load transfers the 18 bits sampled on the 18 edges before the load edge; bits shifted in earlier are discarded.
- R2: A channel loads its holding register at the first rising edge where its strobe is sampled low, provided the strobe was sampled high at the edge before. The new output code is visible after that edge.
- R3: A strobe that stays high, or that stays low after a load, causes no further load. The output holds its value while shifting goes on.
- R4: A load on one channel leaves the other channel's segment and binary outputs unchanged.
- R5: When both data inputs carry the same stream and both strobes carry the same waveform, the two channels present identical outputs.
- R6: Segment bit i (i = 0..14) is 1 exactly when the top 4 bits of the offset-binary code (sample with bit 17 inverted) exceed i. The binary word is bits 13..0 of the sample. So 18'h20000 gives 15'h0000 / 14'h0000, and 18'h1FFFF gives 15'h7FFF / 14'h3FFF.
- R7: Synchronous reset puts the midscale code (sample 0) in both channels' input and holding registers. The segment output becomes 15'h00FF and the binary output 14'h0000 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sdata_l | input | 1 | Left serial data |
| sdata_r | input | 1 | Right serial data |
| strobe_l | input | 1 | Left latch strobe, loads on a falling edge |
| strobe_r | input | 1 | Right latch strobe, loads on a falling edge |
| seg_l | output | 15 | Left segment switch drive (thermometer) |
| bin_l | output | 14 | Left binary ladder switch drive |
| seg_r | output | 15 | Right segment switch drive (thermometer) |
| bin_r | output | 14 | Right binary ladder switch drive |

## Verification
The assertions check a number of rules on every cycle:

- the MSB-first shift of each input register;
- the holding register changes only after a detected strobe fall;
- a strobe fall is never detected on two edges in a row;
- the segment word is a contiguous thermometer whose population equals the top offset-binary field;
- each channel's outputs stay put while its strobe is high;
- the reset code.

The bench scenarios are what show the data path end to end. They show the exact sample captured after extra leading bits, the exact segment and binary values for the extreme and midscale samples, the isolation between channels, and matching results when the inputs are tied.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
   localparam int unsigned DFE_SAMPLE_W = 18;
   localparam int unsigned DFE_SEG_BITS = 4;
   localparam int unsigned DFE_NCH      = 2;
   typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} dfe_chan_e;
endpackage

// File: rtl/dacfe_shift.sv
module dacfe_shift #(
   parameter int unsigned W = 18
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         din,
   output logic [W-1:0] sreg
);
   always_ff @(posedge clk) begin
      if (rst) sreg <= '0;
      else     sreg <= {sreg[W-2:0], din};
   end

   // R1
   shift_msb_first_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (sreg[0] == $past(din)) && (sreg[W-1:1] == $past(sreg[W-2:0])));
endmodule

// File: rtl/dacfe_fall.sv
module dacfe_fall (
   input  logic clk,
   input  logic rst,
   input  logic lat_in,
   output logic fall
);
   logic lat_q;

   always_ff @(posedge clk) begin
      if (rst) lat_q <= 1'b0;
      else     lat_q <= lat_in;
   end

   assign fall = lat_q & ~lat_in;

   // R3
   no_double_fall_chk: assert property (@(posedge clk) disable iff (rst)
      fall |=> !fall);
endmodule

// File: rtl/dacfe_enc.sv
module dacfe_enc #(
   parameter int unsigned W     = 18,
   parameter int unsigned SB    = 4,
   parameter int unsigned STYLE = 0,
   localparam int unsigned NSEG = (1 << SB) - 1,
   localparam int unsigned BW   = W - SB
) (
   input  logic [W-1:0]    code,
   output logic [NSEG-1:0] seg,
   output logic [BW-1:0]   bin
);
   logic [W-1:0]  offs;
   logic [SB-1:0] top;

   assign offs = {~code[W-1], code[W-2:0]};
   assign top  = offs[W-1:W-SB];
   assign bin  = offs[BW-1:0];

   generate
      if (STYLE == 0) begin : g_cmp
         for (genvar i = 0; i < NSEG; i++) begin : g_seg
            assign seg[i] = (top > SB'(i));
         end
      end else begin : g_mask
         always_comb seg = {NSEG{1'b1}} >> (NSEG - int'(top));
      end
   endgenerate

   always_comb begin
      if (!$isunknown(code)) begin
         // R6
         therm_contig_chk: assert ((({1'b0, seg} + 1'b1) & {1'b0, seg}) == '0);
         // R6
         therm_count_chk: assert ($countones(seg) == int'(top));
      end
   end
endmodule

// File: rtl/dacfe_channel.sv
module dacfe_channel #(
   parameter int unsigned W     = 18,
   parameter int unsigned SB    = 4,
   parameter int unsigned STYLE = 0,
   localparam int unsigned NSEG = (1 << SB) - 1,
   localparam int unsigned BW   = W - SB
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            din,
   input  logic            lat_in,
   output logic [NSEG-1:0] seg,
   output logic [BW-1:0]   bin
);
   logic [W-1:0] sreg;
   logic [W-1:0] hold;
   logic         fall;

   dacfe_shift #(.W(W)) u_shift (.clk(clk), .rst(rst), .din(din), .sreg(sreg));
   dacfe_fall u_fall (.clk(clk), .rst(rst), .lat_in(lat_in), .fall(fall));

   always_ff @(posedge clk) begin
      if (rst)       hold <= '0;
      else if (fall) hold <= sreg;
   end

   dacfe_enc #(.W(W), .SB(SB), .STYLE(STYLE)) u_enc (.code(hold), .seg(seg), .bin(bin));

   // R3
   hold_only_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
      !fall |=> $stable(hold));
endmodule

// File: rtl/dual_dac_fe.sv
module dual_dac_fe
   import dacfe_pkg::*;
#(
   parameter int unsigned SAMPLE_W = DFE_SAMPLE_W,
   parameter int unsigned SEG_BITS = DFE_SEG_BITS,
   parameter int unsigned ENC_STYLE = 0,
   localparam int unsigned NSEG = (1 << SEG_BITS) - 1,
   localparam int unsigned BW   = SAMPLE_W - SEG_BITS
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            sdata_l,
   input  logic            sdata_r,
   input  logic            strobe_l,
   input  logic            strobe_r,
   output logic [NSEG-1:0] seg_l,
   output logic [BW-1:0]   bin_l,
   output logic [NSEG-1:0] seg_r,
   output logic [BW-1:0]   bin_r
);
   localparam logic [NSEG-1:0] MID_SEG = {NSEG{1'b1}} >> (NSEG - (1 << (SEG_BITS - 1)));

   generate
      if (SEG_BITS < 1 || SEG_BITS >= SAMPLE_W || SEG_BITS > 5) begin : g_bad_seg
         $error("dual_dac_fe: SEG_BITS out of range");
      end
      if (ENC_STYLE > 1) begin : g_bad_style
         $error("dual_dac_fe: ENC_STYLE must be 0 or 1");
      end
   endgenerate

   logic [DFE_NCH-1:0]  din_v;
   logic [DFE_NCH-1:0]  lat_v;
   logic [NSEG-1:0]     seg_v [DFE_NCH];
   logic [BW-1:0]       bin_v [DFE_NCH];

   assign din_v[CH_LEFT]  = sdata_l;
   assign din_v[CH_RIGHT] = sdata_r;
   assign lat_v[CH_LEFT]  = strobe_l;
   assign lat_v[CH_RIGHT] = strobe_r;

   generate
      for (genvar c = 0; c < DFE_NCH; c++) begin : g_ch
         dacfe_channel #(.W(SAMPLE_W), .SB(SEG_BITS), .STYLE(ENC_STYLE)) u_ch (
            .clk(clk), .rst(rst), .din(din_v[c]), .lat_in(lat_v[c]),
            .seg(seg_v[c]), .bin(bin_v[c]));
      end
   endgenerate

   assign seg_l = seg_v[CH_LEFT];
   assign bin_l = bin_v[CH_LEFT];
   assign seg_r = seg_v[CH_RIGHT];
   assign bin_r = bin_v[CH_RIGHT];

   // R3
   left_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
      strobe_l |=> $stable(seg_l) && $stable(bin_l));
   // R4
   right_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
      strobe_r |=> $stable(seg_r) && $stable(bin_r));
   // R7
   reset_mid_chk: assert property (@(posedge clk)
      rst |=> (seg_l == MID_SEG) && (bin_l == '0) && (seg_r == MID_SEG) && (bin_r == '0));
endmodule

// File: tb/sim_dual_dac_fe.sv
module sim_dual_dac_fe;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sdata_l = 1'b0, sdata_r = 1'b0;
   logic strobe_l = 1'b1, strobe_r = 1'b1;
   logic [14:0] seg_l, seg_r;
   logic [13:0] bin_l, bin_r;

   int n_cmp = 0;
   int n_bad = 0;
   bit run = 1'b0;
   bit chk_l = 1'b0, chk_r = 1'b0;
   string tag_l, tag_r;
   logic [28:0] ql[$];
   logic [28:0] qr[$];
   logic [28:0] model_l, model_r;

   always #4 clk = ~clk;

   dual_dac_fe u0 (.clk(clk), .rst(rst), .sdata_l(sdata_l), .sdata_r(sdata_r),
      .strobe_l(strobe_l), .strobe_r(strobe_r),
      .seg_l(seg_l), .bin_l(bin_l), .seg_r(seg_r), .bin_r(bin_r));

   function automatic logic [28:0] exp_code(input logic [17:0] s);
      logic [17:0] o;
      logic [14:0] sg;
      o  = s ^ 18'h20000;
      sg = 15'((32'd1 << o[17:14]) - 32'd1);
      return {sg, o[13:0]};
   endfunction

   task automatic check(input string tag, input logic [28:0] act, input logic [28:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual seg=%h bin=%h expected seg=%h bin=%h",
                  tag, act[28:14], act[13:0], exp[28:14], exp[13:0]);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (run) begin
         if (chk_l) begin model_l = ql.pop_front(); chk_l = 1'b0;
            check(tag_l, {seg_l, bin_l}, model_l);
         end else check("R3/R4 left hold", {seg_l, bin_l}, model_l);
         if (chk_r) begin model_r = qr.pop_front(); chk_r = 1'b0;
            check(tag_r, {seg_r, bin_r}, model_r);
         end else check("R3/R4 right hold", {seg_r, bin_r}, model_r);
      end
   end

   task automatic junk(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sdata_l = ~sdata_l; sdata_r = (i % 3) == 0;
         @(posedge clk);
      end
   endtask

   task automatic xfer(input logic [17:0] sl, input logic [17:0] sr,
                       input bit dl, input bit dr, input int hold_low, input string tag);
      for (int i = 17; i >= 0; i--) begin
         @(negedge clk); sdata_l = sl[i]; sdata_r = sr[i];
         @(posedge clk);
      end
      @(negedge clk);
      if (dl) begin strobe_l = 1'b0; ql.push_back(exp_code(sl)); tag_l = tag; end
      if (dr) begin strobe_r = 1'b0; qr.push_back(exp_code(sr)); tag_r = tag; end
      @(posedge clk);
      @(negedge clk);
      chk_l = dl; chk_r = dr;
      for (int k = 0; k < hold_low; k++) begin
         sdata_l = ~sdata_l; sdata_r = ~sdata_r;
         @(posedge clk); @(negedge clk);
      end
      strobe_l = 1'b1; strobe_r = 1'b1;
   endtask

   initial begin
      #1500000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      model_l = exp_code(18'h00000);
      model_r = exp_code(18'h00000);
      repeat (4) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      #1;
      // R7: midscale after reset
      check("R7 left reset", {seg_l, bin_l}, {15'h00FF, 14'h0000});
      check("R7 right reset", {seg_r, bin_r}, {15'h00FF, 14'h0000});
      run = 1'b1;
      // R7: input register holds midscale, strobe without shifting new data loads zero code
      @(negedge clk); strobe_l = 1'b0; ql.push_back(exp_code(18'h00000)); tag_l = "R7 input reg";
      @(posedge clk); @(negedge clk); chk_l = 1'b1; strobe_l = 1'b1;
      // R6 extremes, R4 isolation
      xfer(18'h20000, 18'h00000, 1, 0, 0, "R6 left most negative");
      xfer(18'h00000, 18'h1FFFF, 0, 1, 0, "R6 right most positive");
      // R1: extra leading bits discarded
      junk(3);
      xfer(18'h2ABCD, 18'h15432, 1, 1, 0, "R1 last 18 bits");
      // R3: strobe held low while shifting continues
      xfer(18'h12345, 18'h3000F, 1, 0, 6, "R3 held low");
      // R2 patterns on alternating channels
      xfer(18'h0FFFF, 18'h10000, 1, 0, 0, "R2 left 0FFFF");
      xfer(18'h10000, 18'h10000, 0, 1, 0, "R2 right 10000");
      xfer(18'h3FFFF, 18'h04000, 1, 0, 0, "R2 left minus one");
      xfer(18'h3FFFF, 18'h04000, 0, 1, 0, "R2 right 04000");
      // R5: tied inputs
      xfer(18'h3C001, 18'h3C001, 1, 1, 2, "R5 tied");
      @(negedge clk); #1;
      check("R5 tied left equals right", {seg_l, bin_l}, {seg_r, bin_r});
      repeat (3) @(posedge clk);
      @(negedge clk); #2;
      run = 1'b0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule